// File: doc/BRIEF.md
# Time-Shared Distributed-Arithmetic FIR Filter

This block is an 8-tap linear-phase FIR low-pass filter for a fast system clock that runs several cycles per input sample. It contains no multipliers. A sample strobe pushes a signed word into a tap delay line. Mirrored taps are added in pairs, because the coefficients are symmetric. The four pair sums are then consumed two bit planes per clock, from the least significant pair of planes upward.

For each bit plane, one bit from each pair sum forms a 4-bit address into a coefficient-sum table. The two table results for a clock are combined and added into an accumulator, which moves right by two bits every pass. The sign plane of the pair sums is subtracted instead of added. The pair sums are one bit wider than the samples, so a 10-bit sample takes six passes.

A controller with three named states governs the work:
- **ST_IDLE**: waiting for a strobe.
- **ST_PASS**: a non-final pass.
- **ST_FINAL**: the last pass, which publishes the result.

The named transitions are:
- *start* (ST_IDLE to ST_PASS on a strobe)
- *advance* (ST_PASS to ST_PASS)
- *finish* (ST_PASS to ST_FINAL when the pass index reaches the last non-final pass)
- *rearm* (ST_FINAL to ST_PASS on a strobe)
- *drain* (ST_FINAL to ST_IDLE with no strobe)

A strobe that arrives while a non-final pass runs is dropped and sets a sticky overrun flag.

Top module: `fir_da_filter`

## Requirements
- R1: While reset is asserted, and right after it is released, y_out is 0, y_vld is 0 and overrun is 0. All eight taps start at zero.
- R2: Taps and coefficients are arranged as follows:
  - The input is a 10-bit two's-complement sample, and x[0] is the newest accepted sample.
  - With coefficients {-3, 5, 20, 42} for pairs 0..3, each result equals the sum over k of coef[k]*(x[k]+x[7-k]).
  - The result is exact and appears as a 21-bit two's-complement value on y_out.
- R3: y_vld is high for exactly one cycle. It rises 6 clock edges after the edge that accepted the strobe, and y_out carries that sample's result in the same cycle.
- R4: y_out changes only in cycles where y_vld is high. Otherwise it holds its last value.
- R5: A strobe is accepted when the controller is idle or in its final pass. This allows one sample every 6 cycles, back to back, with no result lost and no overrun.
- R6: A strobe during a non-final pass is ignored. The delay line and the running result are untouched, which later results show, and overrun goes high at the next edge.
- R7: overrun stays high until reset.
- R8: Full-scale inputs are exact. Examples are all taps at -512 (pair sums at the most negative value, sign plane subtracted) and all taps at +511.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_stb | input | 1 | Sample strobe, one cycle per new sample |
| smp_in | input | 10 | Signed input sample |
| y_out | output | 21 | Signed filtered result |
| y_vld | output | 1 | One-cycle pulse when y_out is new |
| overrun | output | 1 | Sticky flag for a dropped strobe |

## Verification
The result and its valid pulse are due six rising edges after the edge that accepted a strobe. A dropped strobe shows on overrun one edge after it was sampled. The reference model in the bench advances on the same rising edge that the design sees the strobe on, and tracks the pass countdown, the delay line and the pending result. The outputs are compared at the following falling edge on every cycle. Strobe patterns cover isolated samples, back-to-back strobes landing on the final pass, strobes inside a running pass, and full-scale data.

// File: rtl/fir_da_pkg.sv
package fir_da_pkg;

    // Controller states of the serial distributed-arithmetic engine
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PASS  = 2'd1,
        ST_FINAL = 2'd2
    } da_state_t;

endpackage

// File: rtl/fir_da_seq.sv
module fir_da_seq
    import fir_da_pkg::*;
#(
    parameter int PASSES = 6,
    localparam int IDX_W = (PASSES > 1) ? $clog2(PASSES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_stb,
    output logic             accept,
    output logic             run_en,
    output logic             final_pass,
    output logic [IDX_W-1:0] pass_idx,
    output logic             y_vld,
    output logic             overrun
);

    da_state_t state_q, state_d;

    assign accept     = smp_stb && ((state_q == ST_IDLE) || (state_q == ST_FINAL));
    assign run_en     = (state_q != ST_IDLE);
    assign final_pass = (state_q == ST_FINAL);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_PASS;                 // start
            ST_PASS:  if (pass_idx == IDX_W'(PASSES - 2))
                          state_d = ST_FINAL;                         // finish
                      else
                          state_d = ST_PASS;                          // advance
            ST_FINAL: state_d = accept ? ST_PASS : ST_IDLE;           // rearm / drain
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs and pass index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pass_idx <= '0;
            y_vld    <= 1'b0;
            overrun  <= 1'b0;
        end else begin
            if (accept) begin
                pass_idx <= '0;
            end else if (state_q == ST_PASS) begin
                pass_idx <= pass_idx + 1'b1;
            end
            y_vld   <= final_pass;
            overrun <= overrun | (smp_stb & ~accept);
        end
    end

endmodule

// File: rtl/fir_da_taps.sv
module fir_da_taps #(
    parameter int DATA_W   = 10,
    parameter int NUM_TAPS = 8,
    parameter int SER_W    = 12,
    localparam int PAIRS   = NUM_TAPS / 2,
    localparam int SUM_W   = DATA_W + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        shift_en,
    input  logic [DATA_W-1:0]           smp_in,
    output logic [PAIRS-1:0][SER_W-1:0] pair_sum
);

    logic [NUM_TAPS-1:0][DATA_W-1:0] tap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tap_q <= '0;
        end else if (shift_en) begin
            tap_q <= {tap_q[NUM_TAPS-2:0], smp_in};
        end
    end

    // fold mirrored taps, then sign-extend to the serial word width
    for (genvar k = 0; k < PAIRS; k++) begin : g_fold
        logic [SUM_W-1:0] sum_k;
        assign sum_k = {tap_q[k][DATA_W-1], tap_q[k]}
                     + {tap_q[NUM_TAPS-1-k][DATA_W-1], tap_q[NUM_TAPS-1-k]};
        if (SER_W > SUM_W) begin : g_ext
            assign pair_sum[k] = {{(SER_W - SUM_W){sum_k[SUM_W-1]}}, sum_k};
        end else begin : g_noext
            assign pair_sum[k] = sum_k;
        end
    end

endmodule

// File: rtl/fir_da_lut.sv
module fir_da_lut #(
    parameter int PAIRS  = 4,
    parameter int SER_W  = 12,
    parameter int BPC    = 2,
    parameter int LUT_W  = 10,
    parameter int IDX_W  = 3,
    parameter int COEF [PAIRS] = '{default: 0}
) (
    input  logic [PAIRS-1:0][SER_W-1:0] pair_sum,
    input  logic [IDX_W-1:0]            pass_idx,
    output logic [BPC-1:0][LUT_W-1:0]   plane_val
);

    // coefficient-sum table entry: sum of coefficients whose pair bit is set
    function automatic logic [LUT_W-1:0] table_entry(input logic [PAIRS-1:0] sel);
        int total;
        total = 0;
        for (int k = 0; k < PAIRS; k++) begin
            if (sel[k]) total += COEF[k];
        end
        return LUT_W'(total);
    endfunction

    for (genvar i = 0; i < BPC; i++) begin : g_plane
        logic [PAIRS-1:0] addr;
        always_comb begin
            int plane;
            plane = int'(pass_idx) * BPC + i;
            for (int k = 0; k < PAIRS; k++) begin
                addr[k] = (plane < SER_W) ? pair_sum[k][plane] : pair_sum[k][SER_W-1];
            end
        end
        assign plane_val[i] = table_entry(addr);
    end

endmodule

// File: rtl/fir_da_accum.sv
module fir_da_accum #(
    parameter int BPC    = 2,
    parameter int LUT_W  = 10,
    parameter int PASSES = 6,
    parameter int OUT_W  = 21,
    localparam int ACC_W = OUT_W + BPC,
    localparam int TOP_SH = BPC * (PASSES - 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      en,
    input  logic                      final_pass,
    input  logic [BPC-1:0][LUT_W-1:0] plane_val,
    output logic [OUT_W-1:0]          y_out
);

    logic signed [ACC_W-1:0] acc_q, acc_next, partial;

    // weight the planes of this pass; the sign plane is subtracted
    always_comb begin
        partial = '0;
        for (int i = 0; i < BPC; i++) begin
            logic signed [ACC_W-1:0] term;
            term = {{(ACC_W - LUT_W){plane_val[i][LUT_W-1]}}, plane_val[i]};
            term = term <<< i;
            if (final_pass && (i == BPC - 1)) partial = partial - term;
            else                              partial = partial + term;
        end
        acc_next = (acc_q >>> BPC) + (partial <<< TOP_SH);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            y_out <= '0;
        end else begin
            if (clr)     acc_q <= '0;
            else if (en) acc_q <= acc_next;
            if (final_pass) y_out <= acc_next[OUT_W-1:0];
        end
    end

endmodule

// File: rtl/fir_da_filter.sv
module fir_da_filter #(
    parameter int DATA_W   = 10,
    parameter int NUM_TAPS = 8,
    parameter int COEF_W   = 8,
    parameter int BPC      = 2,
    parameter int COEF [NUM_TAPS/2] = '{-3, 5, 20, 42},
    localparam int PAIRS   = NUM_TAPS / 2,
    localparam int PASSES  = (DATA_W + 1 + BPC - 1) / BPC,
    localparam int SER_W   = PASSES * BPC,
    localparam int LUT_W   = COEF_W + $clog2(PAIRS),
    localparam int OUT_W   = DATA_W + 1 + COEF_W + $clog2(PAIRS),
    localparam int IDX_W   = (PASSES > 1) ? $clog2(PASSES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_stb,
    input  logic [DATA_W-1:0] smp_in,
    output logic [OUT_W-1:0]  y_out,
    output logic              y_vld,
    output logic              overrun
);

    logic                        accept, run_en, final_pass;
    logic [IDX_W-1:0]            pass_idx;
    logic [PAIRS-1:0][SER_W-1:0] pair_sum;
    logic [BPC-1:0][LUT_W-1:0]   plane_val;

    fir_da_seq #(.PASSES(PASSES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_stb    (smp_stb),
        .accept     (accept),
        .run_en     (run_en),
        .final_pass (final_pass),
        .pass_idx   (pass_idx),
        .y_vld      (y_vld),
        .overrun    (overrun)
    );

    fir_da_taps #(.DATA_W(DATA_W), .NUM_TAPS(NUM_TAPS), .SER_W(SER_W)) u_taps (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (accept),
        .smp_in   (smp_in),
        .pair_sum (pair_sum)
    );

    fir_da_lut #(
        .PAIRS(PAIRS), .SER_W(SER_W), .BPC(BPC),
        .LUT_W(LUT_W), .IDX_W(IDX_W), .COEF(COEF)
    ) u_lut (
        .pair_sum  (pair_sum),
        .pass_idx  (pass_idx),
        .plane_val (plane_val)
    );

    fir_da_accum #(.BPC(BPC), .LUT_W(LUT_W), .PASSES(PASSES), .OUT_W(OUT_W)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (accept),
        .en         (run_en),
        .final_pass (final_pass),
        .plane_val  (plane_val),
        .y_out      (y_out)
    );

endmodule

// File: rtl/fir_da_chk.sv
module fir_da_chk #(
    parameter int PASSES = 6,
    parameter int OUT_W  = 21
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_stb,
    input logic [OUT_W-1:0] y_out,
    input logic             y_vld,
    input logic             overrun
);

    localparam int CNT_W = $clog2(PASSES + 1) + 1;

    // passes still owed, tracked from the ports only
    logic [CNT_W-1:0] owed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 owed <= '0;
        else if (smp_stb && (owed <= CNT_W'(1)))    owed <= CNT_W'(PASSES);
        else if (owed != '0)                        owed <= owed - 1'b1;
    end

    p_vld_due_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (owed == CNT_W'(1)) |=> y_vld);

    p_vld_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (owed != CNT_W'(1)) |=> !y_vld);

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !y_vld |-> $stable(y_out));

    p_ovr_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && (owed > CNT_W'(1))) |=> overrun);

    p_ovr_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!overrun && (!smp_stb || (owed <= CNT_W'(1)))) |=> !overrun);

    p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

endmodule

bind fir_da_filter fir_da_chk #(.PASSES(PASSES), .OUT_W(OUT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp_stb (smp_stb),
    .y_out   (y_out),
    .y_vld   (y_vld),
    .overrun (overrun)
);

// File: tb/fir_da_filter_bench.sv
module fir_da_filter_bench;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               smp_stb = 1'b0;
    logic [9:0]         smp_in = '0;
    logic signed [20:0] y_out;
    logic               y_vld;
    logic               overrun;

    int checks = 0;
    int failures = 0;

    // reference model state
    int    hist [8];
    int    coef [4] = '{-3, 5, 20, 42};
    int    owed = 0;
    int    pending = 0;
    int    exp_y = 0;
    bit    exp_vld = 1'b0;
    bit    exp_ovr = 1'b0;
    string tag = "R2";

    fir_da_filter u_fir_da_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_stb (smp_stb),
        .smp_in  (smp_in),
        .y_out   (y_out),
        .y_vld   (y_vld),
        .overrun (overrun)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    task automatic model_edge(input bit stb, input int x);
        exp_vld = (owed == 1);
        if (owed == 1) exp_y = pending;
        if (stb && owed <= 1) begin
            for (int k = 7; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = x;
            pending = 0;
            for (int k = 0; k < 4; k++) pending += coef[k] * (hist[k] + hist[7-k]);
            owed = 6;
        end else begin
            if (stb) exp_ovr = 1'b1;
            if (owed > 0) owed--;
        end
    endtask

    task automatic cyc(input bit stb, input int x);
        smp_stb = stb;
        smp_in  = 10'(x);
        @(posedge clk);
        model_edge(stb, x);
        @(negedge clk);
        check("R3", int'(y_vld), int'(exp_vld));
        check(exp_vld ? tag : "R4", int'(y_out), exp_y);
        check(exp_ovr ? "R7" : "R6", int'(overrun), int'(exp_ovr));
    endtask

    task automatic sample(input int x, input int gap);
        cyc(1'b1, x);
        for (int g = 0; g < gap; g++) cyc(1'b0, 0);
    endtask

    initial begin
        #(8 * 20000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int k = 0; k < 8; k++) hist[k] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", int'(y_out), 0);
        check("R1", int'(y_vld), 0);
        check("R1", int'(overrun), 0);
        rst_n = 1'b1;
        cyc(1'b0, 0);
        check("R1", int'(y_out), 0);

        // R2: impulse response then random isolated samples
        tag = "R2";
        sample(1, 8);
        for (int n = 0; n < 8; n++) sample(0, 7);
        for (int n = 0; n < 20; n++) sample(int'($urandom_range(1023)) - 512, 7);

        // R5: strobes land exactly on the final pass
        tag = "R5";
        for (int n = 0; n < 16; n++) sample(int'($urandom_range(1023)) - 512, 5);
        for (int g = 0; g < 4; g++) cyc(1'b0, 0);

        // R8: full-scale negative and positive
        tag = "R8";
        for (int n = 0; n < 8; n++) sample(-512, 6);
        for (int n = 0; n < 8; n++) sample(511, 6);
        for (int n = 0; n < 8; n++) sample(-512, 6);

        // R6: strobes inside a running pass are dropped
        tag = "R6";
        for (int n = 0; n < 10; n++) begin
            cyc(1'b1, int'($urandom_range(1023)) - 512);
            cyc(1'b0, 0);
            cyc(1'b1, 300);
            cyc(1'b0, 0);
            cyc(1'b1, -300);
            for (int g = 0; g < 4; g++) cyc(1'b0, 0);
        end

        // R7: flag stays up through normal traffic
        tag = "R7";
        for (int n = 0; n < 10; n++) sample(int'($urandom_range(1023)) - 512, 6);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule